// File: doc/BRIEF.md
# Shift-Register LIFO Stack

This block is a last-in first-out stack built as a chain of word registers in which the stored data moves and no pointer is kept. Cell 0 is the top of the stack and cell N-1 is the bottom. A push loads the incoming word into cell 0 and moves every stored word one cell deeper. A pop hands out the word in cell 0 and moves every stored word one cell toward the top. The cells that the shift leaves empty are cleared to zero.

Two reads leave the stack as it is. A peek returns the top word. An indexed read returns the word held at any cell position below the current depth. An occupancy counter gives the depth. It blocks pushes when the stack is full and blocks pops when the stack is empty, and each blocked request raises a one-cycle flag. A push and a pop in the same cycle replace the top word and leave the depth unchanged.

Every request is sampled on a rising clock edge. Its result appears on registered outputs in the cycle after that edge. All reads see the contents as they were before that edge's push or pop.

Top module: `shift_lifo_stack`

## Requirements
- R1: While `rst` is high at a clock edge, the stack empties. After that edge `count_o` is 0, `empty_o` is 1, `full_o` is 0, every word output is 0, and every valid or flag output is 0.
- R2: A push alone with `count_o` below N stores `din_i` at index 0. The word that was at index k moves to index k+1, and `count_o` rises by one.
- R3: A push alone with `count_o` equal to N does not change the contents or the count. `ovf_o` is 1 for exactly the following cycle.
- R4: A pop alone with `count_o` above 0 sets `top_o` to the old index-0 word and `top_vld_o` to 1. The word at index k+1 moves to index k, and `count_o` falls by one.
- R5: A pop with `count_o` equal to 0 does not change the stack. `udf_o` is 1 for the following cycle, and `top_vld_o` is 0 with `top_o` equal to 0.
- R6: A peek (`peek_i`) with a non-empty stack sets `top_o` to the index-0 word and `top_vld_o` to 1, and moves nothing. A peek on an empty stack gives `top_vld_o` = 0 and `top_o` = 0.
- R7: An indexed read (`rd_i`) with `rd_idx_i` below `count_o` returns the word at that index on `rd_data_o`, with `rd_vld_o` = 1 and `rd_bad_o` = 0. The stack does not change.
- R8: An indexed read with `rd_idx_i` at or above `count_o` returns `rd_data_o` = 0, with `rd_bad_o` = 1 and `rd_vld_o` = 0.
- R9: A push and a pop together on a non-empty stack output the old top word as a pop does and load `din_i` into index 0. No other index moves and the count does not change, and this holds even when the stack is full. On an empty stack the pair acts as a push and raises `udf_o`.
- R10: `full_o` is 1 exactly when `count_o` equals N, and `empty_o` is 1 exactly when `count_o` is 0. `count_o` never exceeds N.
- R11: Each result appears in the cycle after the request edge. A read that is made in the same cycle as a push or a pop returns the contents from before that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Pop request |
| peek_i | input | 1 | Read the top word without removing it |
| rd_i | input | 1 | Indexed read request |
| rd_idx_i | input | $clog2(N) | Cell index for an indexed read, 0 = top |
| din_i | input | W | Word to push |
| top_o | output | W | Popped or peeked word |
| top_vld_o | output | 1 | `top_o` carries a word |
| rd_data_o | output | W | Indexed read result |
| rd_vld_o | output | 1 | Indexed read was in range |
| rd_bad_o | output | 1 | Indexed read was at or beyond the depth |
| count_o | output | $clog2(N+1) | Number of stored words |
| full_o | output | 1 | Depth equals N |
| empty_o | output | 1 | Depth is zero |
| ovf_o | output | 1 | Push was refused because the stack was full |
| udf_o | output | 1 | Pop was refused because the stack was empty |

## Verification
The bench builds the stack with N = 4 and W = 8. With these values a 2-bit index covers every cell, and four pushes fill the stack. So every depth from empty to full, and every in-range and out-of-range index at each depth, is reached within a few cycles. A directed pass walks the stack through fill, overflow, replace-when-full, drain and underflow. After that, a long pseudo-random stream of combined push, pop, peek and read requests is checked against an arithmetic model of the cell array kept in the bench.

// File: rtl/shstk_pkg.sv
package shstk_pkg;
  typedef enum logic [1:0] {
    SH_HOLD = 2'd0,
    SH_PUSH = 2'd1,
    SH_POP  = 2'd2,
    SH_SWAP = 2'd3
  } shift_op_t;
endpackage

// File: rtl/shstk_ctrl.sv
module shstk_ctrl
  import shstk_pkg::*;
#(
  parameter int N  = 8,
  parameter int CW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_i,
  input  logic          pop_i,
  output shift_op_t     op_o,
  output logic [CW-1:0] count_q,
  output logic          full_q,
  output logic          empty_q,
  output logic          ovf_q,
  output logic          udf_q
);
  localparam logic [CW-1:0] DEPTH = CW'(N);

  logic          has_word;
  logic          has_room;
  logic [CW-1:0] cnt_nxt;

  assign has_word = (count_q != '0);
  assign has_room = (count_q != DEPTH);

  // decide how the cell chain moves this cycle
  always_comb begin
    op_o = SH_HOLD;
    if (push_i && pop_i)
      op_o = has_word ? SH_SWAP : SH_PUSH;
    else if (push_i)
      op_o = has_room ? SH_PUSH : SH_HOLD;
    else if (pop_i)
      op_o = has_word ? SH_POP : SH_HOLD;
  end

  always_comb begin
    case (op_o)
      SH_PUSH: cnt_nxt = count_q + CW'(1);
      SH_POP:  cnt_nxt = count_q - CW'(1);
      default: cnt_nxt = count_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      ovf_q   <= 1'b0;
      udf_q   <= 1'b0;
    end else begin
      count_q <= cnt_nxt;
      full_q  <= (cnt_nxt == DEPTH);
      empty_q <= (cnt_nxt == '0);
      ovf_q   <= push_i && !pop_i && !has_room;
      udf_q   <= pop_i && !has_word;
    end
  end
endmodule

// File: rtl/shstk_cell.sv
module shstk_cell
  import shstk_pkg::*;
#(
  parameter int W      = 16,
  parameter bit IS_TOP = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  shift_op_t    op_i,
  input  logic [W-1:0] above_i,
  input  logic [W-1:0] below_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_o <= '0;
    end else begin
      case (op_i)
        SH_PUSH: q_o <= above_i;
        SH_POP:  q_o <= below_i;
        SH_SWAP: if (IS_TOP) q_o <= above_i;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/shstk_rdport.sv
module shstk_rdport #(
  parameter int N  = 8,
  parameter int W  = 16,
  parameter int IW = $clog2(N),
  parameter int CW = $clog2(N + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0][W-1:0] cells_i,
  input  logic [CW-1:0]       count_i,
  input  logic                pop_i,
  input  logic                peek_i,
  input  logic                rd_i,
  input  logic [IW-1:0]       idx_i,
  output logic [W-1:0]        top_o,
  output logic                top_vld_o,
  output logic [W-1:0]        rd_data_o,
  output logic                rd_vld_o,
  output logic                rd_bad_o
);
  logic top_hit;
  logic in_range;

  assign top_hit  = (pop_i || peek_i) && (count_i != '0);
  assign in_range = (CW'(idx_i) < count_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      top_o     <= '0;
      top_vld_o <= 1'b0;
      rd_data_o <= '0;
      rd_vld_o  <= 1'b0;
      rd_bad_o  <= 1'b0;
    end else begin
      top_vld_o <= top_hit;
      top_o     <= top_hit ? cells_i[0] : '0;
      rd_vld_o  <= rd_i && in_range;
      rd_bad_o  <= rd_i && !in_range;
      rd_data_o <= (rd_i && in_range) ? cells_i[idx_i] : '0;
    end
  end
endmodule

// File: rtl/shift_lifo_stack.sv
module shift_lifo_stack
  import shstk_pkg::*;
#(
  parameter int N  = 8,
  parameter int W  = 16,
  parameter int IW = $clog2(N),
  parameter int CW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          peek_i,
  input  logic          rd_i,
  input  logic [IW-1:0] rd_idx_i,
  input  logic [W-1:0]  din_i,
  output logic [W-1:0]  top_o,
  output logic          top_vld_o,
  output logic [W-1:0]  rd_data_o,
  output logic          rd_vld_o,
  output logic          rd_bad_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          ovf_o,
  output logic          udf_o
);
  shift_op_t           op;
  logic [N-1:0][W-1:0] cells;

  shstk_ctrl #(.N(N), .CW(CW)) ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .push_i  (push_i),
    .pop_i   (pop_i),
    .op_o    (op),
    .count_q (count_o),
    .full_q  (full_o),
    .empty_q (empty_o),
    .ovf_q   (ovf_o),
    .udf_q   (udf_o)
  );

  for (genvar k = 0; k < N; k++) begin : g_cell
    logic [W-1:0] above;
    logic [W-1:0] below;
    if (k == 0) begin : g_top
      assign above = din_i;
    end else begin : g_mid
      assign above = cells[k-1];
    end
    if (k == N - 1) begin : g_bot
      assign below = '0;
    end else begin : g_up
      assign below = cells[k+1];
    end
    shstk_cell #(.W(W), .IS_TOP(k == 0)) cell_i (
      .clk     (clk),
      .rst     (rst),
      .op_i    (op),
      .above_i (above),
      .below_i (below),
      .q_o     (cells[k])
    );
  end

  shstk_rdport #(.N(N), .W(W), .IW(IW), .CW(CW)) rdport_i (
    .clk       (clk),
    .rst       (rst),
    .cells_i   (cells),
    .count_i   (count_o),
    .pop_i     (pop_i),
    .peek_i    (peek_i),
    .rd_i      (rd_i),
    .idx_i     (rd_idx_i),
    .top_o     (top_o),
    .top_vld_o (top_vld_o),
    .rd_data_o (rd_data_o),
    .rd_vld_o  (rd_vld_o),
    .rd_bad_o  (rd_bad_o)
  );
endmodule

// File: rtl/shift_lifo_stack_chk.sv
module shift_lifo_stack_chk #(
  parameter int N  = 8,
  parameter int CW = $clog2(N + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          push_i,
  input logic          pop_i,
  input logic          peek_i,
  input logic          rd_i,
  input logic [CW-1:0] count_o,
  input logic          full_o,
  input logic          empty_o,
  input logic          ovf_o,
  input logic          udf_o,
  input logic          top_vld_o,
  input logic          rd_vld_o,
  input logic          rd_bad_o
);
  localparam logic [CW-1:0] DEPTH = CW'(N);

  assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (rst)
    count_o <= DEPTH);

  assert_flags_R10: assert property (@(posedge clk) disable iff (rst)
    (full_o == (count_o == DEPTH)) && (empty_o == (count_o == '0)));

  assert_push_cnt_R2: assert property (@(posedge clk) disable iff (rst)
    (push_i && !pop_i && !full_o) |=> (count_o == $past(count_o) + CW'(1)) && !ovf_o);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    (push_i && !pop_i && full_o) |=> ovf_o && $stable(count_o));

  assert_pop_cnt_R4: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !push_i && !empty_o) |=> (count_o == $past(count_o) - CW'(1)) && top_vld_o);

  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !push_i && empty_o) |=> udf_o && !top_vld_o && (count_o == '0));

  assert_peek_R6: assert property (@(posedge clk) disable iff (rst)
    (peek_i && !push_i && !pop_i) |=> $stable(count_o) && (top_vld_o == !empty_o));

  assert_rd_excl_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd_vld_o, rd_bad_o}));

  assert_rd_answer_R7: assert property (@(posedge clk) disable iff (rst)
    rd_i |=> (rd_vld_o || rd_bad_o));

  assert_swap_R9: assert property (@(posedge clk) disable iff (rst)
    (push_i && pop_i && !empty_o) |=> $stable(count_o) && top_vld_o && !udf_o);
endmodule

bind shift_lifo_stack shift_lifo_stack_chk #(.N(N), .CW(CW)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .push_i    (push_i),
  .pop_i     (pop_i),
  .peek_i    (peek_i),
  .rd_i      (rd_i),
  .count_o   (count_o),
  .full_o    (full_o),
  .empty_o   (empty_o),
  .ovf_o     (ovf_o),
  .udf_o     (udf_o),
  .top_vld_o (top_vld_o),
  .rd_vld_o  (rd_vld_o),
  .rd_bad_o  (rd_bad_o)
);

// File: tb/shift_lifo_stack_tb_top.sv
`timescale 1ns/1ps
module shift_lifo_stack_tb_top;
  localparam int N  = 4;
  localparam int W  = 8;
  localparam int IW = 2;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          push_i = 1'b0, pop_i = 1'b0, peek_i = 1'b0, rd_i = 1'b0;
  logic [IW-1:0] rd_idx_i = '0;
  logic [W-1:0]  din_i = '0;
  logic [W-1:0]  top_o, rd_data_o;
  logic          top_vld_o, rd_vld_o, rd_bad_o, full_o, empty_o, ovf_o, udf_o;
  logic [CW-1:0] count_o;

  always #4 clk = ~clk;

  shift_lifo_stack #(.N(N), .W(W)) dut_i (
    .clk(clk), .rst(rst), .push_i(push_i), .pop_i(pop_i), .peek_i(peek_i),
    .rd_i(rd_i), .rd_idx_i(rd_idx_i), .din_i(din_i), .top_o(top_o),
    .top_vld_o(top_vld_o), .rd_data_o(rd_data_o), .rd_vld_o(rd_vld_o),
    .rd_bad_o(rd_bad_o), .count_o(count_o), .full_o(full_o), .empty_o(empty_o),
    .ovf_o(ovf_o), .udf_o(udf_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [W-1:0] mdl [N];
  int m = 0;

  task automatic chk(input string rq, input string what, input logic [15:0] a, input logic [15:0] e);
    n_chk++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, a, e);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // one request cycle: drive, compute expectation from the model, check after the edge
  task automatic step(input logic pu, input logic po, input logic pk, input logic rd,
                      input int ix, input logic [W-1:0] d);
    logic swap, dpush, dpop, e_ovf, e_udf, e_tv, e_rv, e_rb;
    logic [W-1:0] e_top, e_rd;
    int e_cnt;
    string t_top, t_rd, t_cnt;
    @(negedge clk);
    push_i = pu; pop_i = po; peek_i = pk; rd_i = rd; rd_idx_i = IW'(ix); din_i = d;
    swap  = pu && po && (m > 0);
    dpush = (pu && !po && m < N) || (pu && po && m == 0);
    dpop  = po && !pu && m > 0;
    e_ovf = pu && !po && m == N;
    e_udf = po && m == 0;
    e_tv  = (po || pk) && m > 0;
    e_top = e_tv ? mdl[0] : '0;
    e_rv  = rd && ix < m;
    e_rb  = rd && ix >= m;
    e_rd  = e_rv ? mdl[ix] : '0;
    e_cnt = m + (dpush ? 1 : 0) - (dpop ? 1 : 0);
    t_top = (pu && po) ? "R9" : po ? (m > 0 ? "R4" : "R5") : "R6";
    t_rd  = (pu || po) ? "R11" : (ix < m ? "R7" : "R8");
    t_cnt = swap ? "R9" : e_ovf ? "R3" : dpush ? "R2" : dpop ? "R4" : "R5";
    @(posedge clk);
    #1;
    chk(t_cnt, "count", 16'(count_o), 16'(e_cnt));
    chk("R10", "full", 16'(full_o), 16'(e_cnt == N));
    chk("R10", "empty", 16'(empty_o), 16'(e_cnt == 0));
    chk("R3", "ovf", 16'(ovf_o), 16'(e_ovf));
    chk("R5", "udf", 16'(udf_o), 16'(e_udf));
    chk(t_top, "top", {7'd0, top_vld_o, top_o}, {7'd0, e_tv, e_top});
    chk(t_rd, "rd", {6'd0, rd_vld_o, rd_bad_o, rd_data_o}, {6'd0, e_rv, e_rb, e_rd});
    if (swap) mdl[0] = d;
    else if (dpush) begin
      for (int k = N - 1; k > 0; k--) mdl[k] = mdl[k-1];
      mdl[0] = d;
    end else if (dpop) begin
      for (int k = 0; k < N - 1; k++) mdl[k] = mdl[k+1];
      mdl[N-1] = '0;
    end
    m = e_cnt;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] lf;
    for (int k = 0; k < N; k++) mdl[k] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: state after reset
    chk("R1", "count", 16'(count_o), 16'd0);
    chk("R1", "empty/full", {14'd0, empty_o, full_o}, 16'h2);
    chk("R1", "flags", {11'd0, top_vld_o, rd_vld_o, rd_bad_o, ovf_o, udf_o}, 16'd0);
    chk("R1", "words", {top_o, rd_data_o}, 16'd0);
    step(0, 1, 0, 0, 0, 8'h00);              // pop on empty
    step(0, 0, 1, 1, 0, 8'h00);              // peek and read on empty
    for (int i = 0; i < N + 1; i++)
      step(1, 0, 0, 1, i % N, 8'(8'h11 * (i + 1)));  // fill with concurrent reads
    step(1, 1, 0, 0, 0, 8'hA5);              // replace when full
    for (int i = 0; i < N; i++) step(0, 0, 0, 1, i, 8'h00);
    step(0, 0, 1, 0, 0, 8'h00);
    for (int i = 0; i < N + 1; i++) step(0, 1, 0, 1, 0, 8'h00);
    step(1, 1, 0, 0, 0, 8'h5A);              // push+pop on empty
    for (int lvl = 0; lvl <= N; lvl++) begin
      while (m > lvl) step(0, 1, 0, 0, 0, 8'h00);
      while (m < lvl) step(1, 0, 0, 0, 0, 8'(8'h30 + m));
      for (int ix = 0; ix < N; ix++) step(0, 0, 0, 1, ix, 8'h00);
    end
    lf = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[0], lf[1] & lf[5], lf[2], lf[3], int'(lf[7:6]), lf[15:8]);
    end
    step(0, 0, 0, 0, 0, 8'h00);
    finish_run();
  end
endmodule